// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This block merges the four interrupt causes of a FIFO-capable serial port into one prioritized identification byte and one interrupt request pin. The receiver supplies a line-status condition, a data-available level and a character-timeout level. The transmitter supplies a holding-register-empty level and a strobe for each write to the holding register. The modem-status logic supplies a delta level. A 4-bit enable mask selects which causes take part.

The identification byte is combinational from the current source levels and the internal holding-empty latch. Software can therefore read it repeatedly, servicing one cause per read, until the pending flag in bit 0 shows nothing left. The holding-empty cause is the only one the block latches itself. A read that reports it, or a write to the holding register, retires it. It is re-armed when the holding register becomes empty again, or when its enable bit is switched on while the register is empty. The request pin is gated by the output-enable bit of the modem control register.

Top module: `irq_ident`

## Requirements
- R1: `id_o[0]` is 0 when at least one enabled cause is pending and 1 otherwise. With nothing pending and FIFOs off, `id_o` reads 8'h01.
- R2: An enabled line-status cause (`lsr_evt_i` with `ier_i[2]`) has the highest priority and gives `id_o[5:0]` = 6'h06.
- R3: Received data available (`rda_evt_i` with `ier_i[0]`, no timeout) gives 6'h04. It ranks below line status and above all other causes.
- R4: A character timeout (`cto_evt_i` with `ier_i[0]`) gives 6'h0C. It has the same rank as received data and takes precedence over it when both are set.
- R5: A pending, enabled holding-empty cause (`ier_i[1]`) gives 6'h02. It ranks below both receiver causes.
- R6: An enabled modem-status cause (`msr_evt_i` with `ier_i[3]`) has the lowest priority and gives 6'h00.
- R7: `id_o[7:6]` reads 2'b11 while `fifo_en_i` is 1 and 2'b00 otherwise. `id_o[5:4]` is always 0.
- R8: An `id_rd_i` pulse while the holding-empty cause is the one reported clears that cause from the next cycle on. A read while a higher cause is reported leaves it pending.
- R9: A `thr_write_i` pulse clears the holding-empty cause from the next cycle on.
- R10: The holding-empty cause is armed on the cycle after `thr_empty_i` goes from 0 to 1. It is also armed on the cycle after `ier_i[1]` goes from 0 to 1 while `thr_empty_i` is 1. An arm event takes precedence over a clear in the same cycle.
- R11: `irq_o` is 1 exactly when `out_en_i` is 1 and `id_o[0]` is 0.
- R12: A cause whose enable bit is 0 has no effect on `id_o` or `irq_o`.
- R13: Line-status, data and timeout causes follow their input levels. A read does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lsr_evt_i | input | 1 | Receiver line-status condition level |
| rda_evt_i | input | 1 | Received data available level |
| cto_evt_i | input | 1 | Character timeout level |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| thr_write_i | input | 1 | Write strobe to the transmit holding register |
| msr_evt_i | input | 1 | Modem-status delta level |
| ier_i | input | 4 | Enables: 0 data/timeout, 1 holding empty, 2 line status, 3 modem |
| fifo_en_i | input | 1 | FIFOs enabled |
| id_rd_i | input | 1 | Read strobe for the identification register |
| out_en_i | input | 1 | Output-enable bit of modem control |
| id_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the priority of line status, the FIFO flag bits, and the gating of the request pin by output enable and the pending flag. They also check that the holding-empty latch obeys its arm and clear rules at each clock edge. Only the bench's scenarios show the full sequence of a service loop: read, observe the next lower cause, read again until bit 0 rises. The same holds for enables toggled under a pending holding-empty cause and for collisions of write, read and re-arm in one cycle. A reference model run beside random traffic covers these.

// File: rtl/irq_ident_pkg.sv
package irq_ident_pkg;

    localparam int NUM_SRC = 4;
    localparam int CODE_W  = 6;

    // priority index: 0 is highest
    localparam int P_LINE = 0;
    localparam int P_RX   = 1;
    localparam int P_THRE = 2;
    localparam int P_MDM  = 3;

    localparam logic [CODE_W-1:0] CODE_NONE = 6'h01;
    localparam logic [CODE_W-1:0] CODE_LINE = 6'h06;
    localparam logic [CODE_W-1:0] CODE_RDA  = 6'h04;
    localparam logic [CODE_W-1:0] CODE_CTO  = 6'h0C;
    localparam logic [CODE_W-1:0] CODE_THRE = 6'h02;
    localparam logic [CODE_W-1:0] CODE_MDM  = 6'h00;

    typedef struct packed {
        logic pend;
        logic empty_prev;
        logic en_prev;
    } thre_state_t;

endpackage

// File: rtl/irq_thre_track.sv
module irq_thre_track
    import irq_ident_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty_i,
    input  logic thr_en_i,
    input  logic thr_write_i,
    input  logic rd_clear_i,
    output logic pend_o,
    output logic arm_o
);

    thre_state_t st_d, st_q;
    logic        arm;
    logic        clr;

    always_comb begin
        st_d = st_q;
        arm  = (thr_empty_i && !st_q.empty_prev) ||
               (thr_en_i && !st_q.en_prev && thr_empty_i);
        clr  = thr_write_i || rd_clear_i;
        st_d.pend       = arm || (st_q.pend && !clr);
        st_d.empty_prev = thr_empty_i;
        st_d.en_prev    = thr_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign arm_o  = arm;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_ident_pkg::*;
(
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               cto_i,
    input  logic               fifo_en_i,
    output logic [7:0]         id_o,
    output logic [NUM_SRC-1:0] sel_o
);

    logic [CODE_W-1:0] code;

    always_comb begin
        sel_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                sel_o    = '0;
                sel_o[i] = 1'b1;
            end
        end
    end

    always_comb begin
        unique case (1'b1)
            sel_o[P_LINE]: code = CODE_LINE;
            sel_o[P_RX]:   code = cto_i ? CODE_CTO : CODE_RDA;
            sel_o[P_THRE]: code = CODE_THRE;
            sel_o[P_MDM]:  code = CODE_MDM;
            default:       code = CODE_NONE;
        endcase
    end

    assign id_o = {{2{fifo_en_i}}, code};

endmodule

// File: rtl/irq_ident.sv
module irq_ident
    import irq_ident_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lsr_evt_i,
    input  logic       rda_evt_i,
    input  logic       cto_evt_i,
    input  logic       thr_empty_i,
    input  logic       thr_write_i,
    input  logic       msr_evt_i,
    input  logic [3:0] ier_i,
    input  logic       fifo_en_i,
    input  logic       id_rd_i,
    input  logic       out_en_i,
    output logic [7:0] id_o,
    output logic       irq_o
);

    logic               thre_pend;
    logic               thre_arm;
    logic               rd_clear;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] sel;

    always_comb begin
        req         = '0;
        req[P_LINE] = lsr_evt_i & ier_i[2];
        req[P_RX]   = (rda_evt_i | cto_evt_i) & ier_i[0];
        req[P_THRE] = thre_pend & ier_i[1];
        req[P_MDM]  = msr_evt_i & ier_i[3];
    end

    assign rd_clear = id_rd_i & sel[P_THRE];

    irq_thre_track u_thre (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_empty_i (thr_empty_i),
        .thr_en_i    (ier_i[1]),
        .thr_write_i (thr_write_i),
        .rd_clear_i  (rd_clear),
        .pend_o      (thre_pend),
        .arm_o       (thre_arm)
    );

    irq_prio_enc u_enc (
        .req_i     (req),
        .cto_i     (cto_evt_i),
        .fifo_en_i (fifo_en_i),
        .id_o      (id_o),
        .sel_o     (sel)
    );

    assign irq_o = out_en_i & ~id_o[0];

endmodule

// File: rtl/irq_ident_chk.sv
module irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lsr_evt_i,
    input logic       thr_empty_i,
    input logic       thr_write_i,
    input logic [3:0] ier_i,
    input logic       fifo_en_i,
    input logic       id_rd_i,
    input logic       out_en_i,
    input logic [7:0] id_o,
    input logic       irq_o,
    input logic       pend,
    input logic       arm
);

    // R2
    line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_evt_i && ier_i[2]) |-> (id_o[5:0] == 6'h06));

    // R7
    fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_o[7:6] == {2{fifo_en_i}});

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (out_en_i && !id_o[0]));

    // R11
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |-> !irq_o);

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd_i && id_o[5:0] == 6'h02 && !arm) |=> !pend);

    // R9
    write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_write_i && !arm) |=> !pend);

    // R10
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_empty_i) |=> pend);

endmodule

bind irq_ident irq_ident_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lsr_evt_i   (lsr_evt_i),
    .thr_empty_i (thr_empty_i),
    .thr_write_i (thr_write_i),
    .ier_i       (ier_i),
    .fifo_en_i   (fifo_en_i),
    .id_rd_i     (id_rd_i),
    .out_en_i    (out_en_i),
    .id_o        (id_o),
    .irq_o       (irq_o),
    .pend        (thre_pend),
    .arm         (thre_arm)
);

// File: tb/irq_ident_tb_top.sv
module irq_ident_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lsr_evt_i = 0, rda_evt_i = 0, cto_evt_i = 0;
    logic       thr_empty_i = 0, thr_write_i = 0, msr_evt_i = 0;
    logic [3:0] ier_i = 4'h0;
    logic       fifo_en_i = 0, id_rd_i = 0, out_en_i = 0;
    logic [7:0] id_o;
    logic       irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // bench reference state
    bit m_pend = 0, m_te_prev = 0, m_en_prev = 0;

    always #10 clk = ~clk;

    irq_ident dut_i (
        .clk(clk), .rst_n(rst_n),
        .lsr_evt_i(lsr_evt_i), .rda_evt_i(rda_evt_i), .cto_evt_i(cto_evt_i),
        .thr_empty_i(thr_empty_i), .thr_write_i(thr_write_i),
        .msr_evt_i(msr_evt_i), .ier_i(ier_i), .fifo_en_i(fifo_en_i),
        .id_rd_i(id_rd_i), .out_en_i(out_en_i), .id_o(id_o), .irq_o(irq_o)
    );

    function automatic logic [5:0] exp_code();
        if (lsr_evt_i && ier_i[2])                   return 6'h06;
        if (cto_evt_i && ier_i[0])                   return 6'h0C;
        if (rda_evt_i && ier_i[0])                   return 6'h04;
        if (m_pend && ier_i[1])                      return 6'h02;
        if (msr_evt_i && ier_i[3])                   return 6'h00;
        return 6'h01;
    endfunction

    function automatic logic [7:0] exp_id();
        return {{2{fifo_en_i}}, exp_code()};
    endfunction

    function automatic string tag_of(logic [5:0] c);
        case (c)
            6'h06:   return "R2";
            6'h0C:   return "R4";
            6'h04:   return "R3";
            6'h02:   return "R5";
            6'h00:   return "R6";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string tag);
        logic [7:0] e;
        logic       ei;
        e  = exp_id();
        ei = out_en_i && !e[0];
        n_run++;
        if (id_o !== e) begin
            n_fail++;
            $display("FAIL %s id_o=%h expected=%h", tag, id_o, e);
        end
        n_run++;
        if (irq_o !== ei) begin
            n_fail++;
            $display("FAIL R11 (%s) irq_o=%b expected=%b", tag, irq_o, ei);
        end
    endtask

    task automatic model_edge();
        bit arm, clr;
        arm = (thr_empty_i && !m_te_prev) || (ier_i[1] && !m_en_prev && thr_empty_i);
        clr = thr_write_i || (id_rd_i && exp_code() == 6'h02);
        m_pend    = arm || (m_pend && !clr);
        m_te_prev = thr_empty_i;
        m_en_prev = ier_i[1];
    endtask

    // inputs are set just after a falling edge; check then advance one cycle
    task automatic tick(input string tag);
        #2;
        check(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic clear_all();
        lsr_evt_i = 0; rda_evt_i = 0; cto_evt_i = 0; msr_evt_i = 0;
        thr_write_i = 0; id_rd_i = 0;
    endtask

    initial begin
        #(20 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, nothing pending
        tick("R1 reset");

        // R10: enable 0->1 with register empty arms; R12 disabled first
        thr_empty_i = 1; tick("R12 thre disabled");
        ier_i = 4'h2;    tick("R10 enable rise");
        out_en_i = 1;    tick("R5 thre reported");
        // R8: read retires it
        id_rd_i = 1;     tick("R8 read while thre");
        id_rd_i = 0;     tick("R8 after read");
        // R10: empty rising edge re-arms
        thr_empty_i = 0; tick("R10 busy");
        thr_empty_i = 1; tick("R10 empty rise");
        // R8: read under higher cause keeps it; R13 line cause stays
        ier_i = 4'hF; lsr_evt_i = 1; id_rd_i = 1; tick("R8 read under line");
        id_rd_i = 0;     tick("R13 line held");
        lsr_evt_i = 0; rda_evt_i = 1; tick("R3 data");
        cto_evt_i = 1;   tick("R4 timeout over data");
        rda_evt_i = 0; cto_evt_i = 0; msr_evt_i = 1; tick("R5 thre over modem");
        // R9: write clears
        thr_write_i = 1; tick("R9 write");
        thr_write_i = 0; tick("R6 modem only");
        fifo_en_i = 1;   tick("R7 fifo bits");
        out_en_i = 0;    tick("R11 gated");
        msr_evt_i = 0; ier_i = 4'h0; lsr_evt_i = 1; rda_evt_i = 1; out_en_i = 1;
        tick("R12 all disabled");
        clear_all();

        for (int i = 0; i < 4000; i++) begin
            lsr_evt_i   = ($urandom % 6) == 0;
            rda_evt_i   = ($urandom % 3) == 0;
            cto_evt_i   = ($urandom % 5) == 0;
            msr_evt_i   = ($urandom % 4) == 0;
            id_rd_i     = ($urandom % 3) == 0;
            thr_write_i = ($urandom % 8) == 0;
            if (($urandom % 4) == 0) thr_empty_i = ~thr_empty_i;
            if (($urandom % 10) == 0) ier_i = 4'($urandom);
            if (($urandom % 20) == 0) fifo_en_i = ~fifo_en_i;
            if (($urandom % 15) == 0) out_en_i = ~out_en_i;
            #2;
            check(tag_of(exp_code()));
            @(posedge clk);
            model_edge();
            @(negedge clk);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule